// File: doc/BRIEF.md
# Pixel-Serial Imager Scan Sequencer

This block reads out a small gray-scale analog image sensor whose pixel address cannot be written directly. The sensor's internal row and column pointers move only when the block pulses its control pins. The block clears both pointers, then steps them one position at a time across the frame in raster order. After each step it waits a programmable settle interval and then runs one 16-clock conversion on an external serial ADC over an SPI-style link (chip select, serial clock, data in). The 12-bit result is sent downstream unchanged, together with its row and column index.

Output leaves on a valid/ready stream. Flags mark the first and the last pixel of a frame. The scan stops in place while the consumer holds ready low, so no pixel storage is needed. A frame begins only on a start request that arrives while the block is idle. A minimum spacing between accepted starts bounds the frame rate. Pulse width and settle time come from configuration inputs and are counted in clock cycles.

Top module: `pix_scan_seq`

## Requirements
- R1: After reset all four address pins are low, `adc_cs_n` is high, `adc_sclk` is low and `pix_valid` is low.
- R2: When `frame_start` is sampled high while idle and the pacing window is open, `img_row_clr` is high in the very next cycle. A `frame_start` arriving while a frame is in progress has no effect, so exactly one row-clear pulse occurs per frame.
- R3: After a start is accepted at clock edge A, starts sampled at edges up to A+MIN_FRAME_CYC-1 are ignored, even when the block is idle. A start sampled at edge A+MIN_FRAME_CYC or later is accepted.
- R4: Each address pulse stays high for max(`cfg_pulse_w`,1) cycles, and at most one of the four address pins is high in any cycle.
- R5: Each frame opens with one `img_row_clr` pulse. Every row starts with an `img_col_clr` pulse, which follows `img_row_clr` for row 0 and `img_row_step` for the other rows. Every pixel after the first in a row is preceded by one `img_col_step` pulse. The per-frame counts are therefore 1, ROWS, ROWS-1 and ROWS*(COLS-1).
- R6: After a column-clear or column-step pulse falls, `adc_cs_n` stays high for exactly max(`cfg_settle`,1) cycles before it falls.
- R7: Each conversion holds `adc_cs_n` low for exactly 16 rising edges of `adc_sclk`. Each high phase of `adc_sclk` lasts SCLK_HALF cycles. `adc_sclk` is low whenever `adc_cs_n` is high, and no address pin pulses while `adc_cs_n` is low.
- R8: `adc_miso` is sampled on each rising `adc_sclk` edge. Of the 16 bits received (first bit = bit 15), bits 15..14 are leading zeros and bits 1..0 are discarded. Bits 13..2, MSB first, appear unchanged on `pix_data`.
- R9: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_data`, `pix_row` and `pix_col` hold their values.
- R10: Pixels leave in raster order, column fastest, with `pix_row`/`pix_col` giving the position. `pix_sof` is high only with pixel (0,0) and `pix_eof` only with pixel (ROWS-1,COLS-1).
- R11: After the end-of-frame handshake the block stays idle until the next accepted start: no address pulse, no conversion and no valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Request to capture one frame |
| cfg_pulse_w | input | CNT_W | Address pulse width in cycles (0 acts as 1) |
| cfg_settle | input | CNT_W | Settle cycles before a conversion (0 acts as 1) |
| img_row_clr | output | 1 | Sensor row pointer clear pulse |
| img_col_clr | output | 1 | Sensor column pointer clear pulse |
| img_row_step | output | 1 | Sensor row pointer advance pulse |
| img_col_step | output | 1 | Sensor column pointer advance pulse |
| adc_cs_n | output | 1 | ADC chip select, active low |
| adc_sclk | output | 1 | ADC serial clock, idle low |
| adc_miso | input | 1 | ADC serial data |
| pix_valid | output | 1 | Pixel stream valid |
| pix_ready | input | 1 | Pixel stream ready |
| pix_data | output | DW | Pixel sample |
| pix_row | output | RW | Row index of the pixel |
| pix_col | output | CW | Column index of the pixel |
| pix_sof | output | 1 | First pixel of frame |
| pix_eof | output | 1 | Last pixel of frame |

## Verification
Two functions can coincide: the arrival of a start request, and the end of a frame or of the pacing window. The bench raises a start in the cycle right after the last pixel's handshake, while the block is idle but pacing is still closed, and expects the row-clear pin to stay low. It then presents a start one edge before and exactly at the pacing boundary, expecting rejection and then acceptance in the following cycle. Further starts are injected in the middle of frames while the consumer stalls at random. Each is judged by the per-frame pulse counts and by the raster indices of the stream.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW_CLR,
    ST_COL_CLR,
    ST_ROW_ADV,
    ST_COL_ADV,
    ST_SETTLE,
    ST_CONV,
    ST_OUT
  } seq_st_e;

  // A programmed length of zero is promoted to one cycle.
  function automatic int unsigned pss_eff(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Timed states are those whose exit is decided by the shared timer.
  function automatic logic pss_timed(input seq_st_e s);
    return (s == ST_ROW_CLR) || (s == ST_COL_CLR) || (s == ST_ROW_ADV) ||
           (s == ST_COL_ADV) || (s == ST_SETTLE);
  endfunction

endpackage

// File: rtl/pss_step_timer.sv
module pss_step_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (ld)            cnt <= ld_val - CNT_W'(1);
    else if (cnt != '0)     cnt <= cnt - CNT_W'(1);
  end

  assign expired = (cnt == '0);

  // R4: the sequencer never asks for a zero-length interval
  p_load_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> (ld_val != '0));

endmodule

// File: rtl/pss_frame_pacer.sv
module pss_frame_pacer #(
  parameter int MIN_CYC = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_go,
  output logic open_q
);

  localparam int FW = (MIN_CYC > 1) ? $clog2(MIN_CYC + 1) : 1;

  logic [FW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (frame_go)     left <= FW'(MIN_CYC - 1);
    else if (left != '0)   left <= left - FW'(1);
  end

  assign open_q = (left == '0);

  generate
    if (MIN_CYC > 1) begin : g_chk
      // R3: an accepted start closes the window on the next cycle
      p_window_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_go |=> !open_q);
    end
  endgenerate

endmodule

// File: rtl/pss_adc_xfer.sv
module pss_adc_xfer #(
  parameter int FRAME_BITS = 16,
  parameter int LEAD       = 2,
  parameter int DW         = 12,
  parameter int HALF       = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          miso,
  output logic          cs_n,
  output logic          sclk,
  output logic          done,
  output logic [DW-1:0] sample
);

  localparam int DVW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW  = $clog2(FRAME_BITS + 1);
  localparam int TOP = FRAME_BITS - 1 - LEAD;

  logic                  active;
  logic [DVW-1:0]        dcnt;
  logic [BW-1:0]         nfall;
  logic [FRAME_BITS-1:0] shreg;
  logic                  sclk_q;
  logic                  done_q;
  logic                  tick;

  assign tick = active && (dcnt == DVW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      dcnt   <= '0;
      nfall  <= '0;
      shreg  <= '0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go && !active) begin
        active <= 1'b1;
        dcnt   <= '0;
        nfall  <= '0;
        sclk_q <= 1'b0;
      end else if (active) begin
        if (tick) begin
          dcnt   <= '0;
          sclk_q <= ~sclk_q;
          if (!sclk_q) begin
            shreg <= {shreg[FRAME_BITS-2:0], miso};
          end else begin
            if (nfall == BW'(FRAME_BITS - 1)) begin
              active <= 1'b0;
              done_q <= 1'b1;
            end
            nfall <= nfall + BW'(1);
          end
        end else begin
          dcnt <= dcnt + DVW'(1);
        end
      end
    end
  end

  assign cs_n   = ~active;
  assign sclk   = sclk_q;
  assign done   = done_q;
  assign sample = shreg[TOP -: DW];

  // R7: serial clock rests low outside a transaction
  p_sclk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R7: a conversion is requested only while the link is free
  p_go_when_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> cs_n);

endmodule

// File: rtl/pix_scan_seq.sv
module pix_scan_seq
  import pss_pkg::*;
#(
  parameter int COLS          = 112,
  parameter int ROWS          = 112,
  parameter int DW            = 12,
  parameter int ADC_BITS      = 16,
  parameter int ADC_LEAD      = 2,
  parameter int SCLK_HALF     = 2,
  parameter int CNT_W         = 8,
  parameter int MIN_FRAME_CYC = 5_000_000,
  localparam int CW           = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int RW           = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [CNT_W-1:0] cfg_pulse_w,
  input  logic [CNT_W-1:0] cfg_settle,
  output logic             img_row_clr,
  output logic             img_col_clr,
  output logic             img_row_step,
  output logic             img_col_step,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  input  logic             adc_miso,
  output logic             pix_valid,
  input  logic             pix_ready,
  output logic [DW-1:0]    pix_data,
  output logic [RW-1:0]    pix_row,
  output logic [CW-1:0]    pix_col,
  output logic             pix_sof,
  output logic             pix_eof
);

  seq_st_e st, st_n;

  // named internal events
  logic             frame_go;
  logic             pace_open;
  logic             tmr_ld;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_exp;
  logic             adc_go;
  logic             adc_done;
  logic [DW-1:0]    adc_sample;
  logic             px_fire;
  logic             last_col;
  logic             last_row;

  logic [RW-1:0]    row_q;
  logic [CW-1:0]    col_q;
  logic [DW-1:0]    data_q;

  assign frame_go = (st == ST_IDLE) && frame_start && pace_open;
  assign px_fire  = (st == ST_OUT) && pix_ready;
  assign last_col = (col_q == CW'(COLS - 1));
  assign last_row = (row_q == RW'(ROWS - 1));
  assign adc_go   = (st == ST_SETTLE) && tmr_exp;

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE:    if (frame_go) st_n = ST_ROW_CLR;
      ST_ROW_CLR: if (tmr_exp)  st_n = ST_COL_CLR;
      ST_ROW_ADV: if (tmr_exp)  st_n = ST_COL_CLR;
      ST_COL_CLR: if (tmr_exp)  st_n = ST_SETTLE;
      ST_COL_ADV: if (tmr_exp)  st_n = ST_SETTLE;
      ST_SETTLE:  if (tmr_exp)  st_n = ST_CONV;
      ST_CONV:    if (adc_done) st_n = ST_OUT;
      ST_OUT: begin
        if (px_fire) begin
          if (!last_col)     st_n = ST_COL_ADV;
          else if (last_row) st_n = ST_IDLE;
          else               st_n = ST_ROW_ADV;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign tmr_ld  = (st_n != st) && pss_timed(st_n);
  assign tmr_val = (st_n == ST_SETTLE) ? CNT_W'(pss_eff(int'(cfg_settle)))
                                       : CNT_W'(pss_eff(int'(cfg_pulse_w)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (frame_go) begin
      row_q <= '0;
      col_q <= '0;
    end else if (px_fire) begin
      if (last_col) begin
        col_q <= '0;
        row_q <= last_row ? '0 : row_q + RW'(1);
      end else begin
        col_q <= col_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (adc_done) data_q <= adc_sample;
  end

  pss_step_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (tmr_ld),
    .ld_val  (tmr_val),
    .expired (tmr_exp)
  );

  pss_frame_pacer #(.MIN_CYC(MIN_FRAME_CYC)) u_pace (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_go (frame_go),
    .open_q   (pace_open)
  );

  pss_adc_xfer #(
    .FRAME_BITS (ADC_BITS),
    .LEAD       (ADC_LEAD),
    .DW         (DW),
    .HALF       (SCLK_HALF)
  ) u_adc (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (adc_go),
    .miso   (adc_miso),
    .cs_n   (adc_cs_n),
    .sclk   (adc_sclk),
    .done   (adc_done),
    .sample (adc_sample)
  );

  assign img_row_clr  = (st == ST_ROW_CLR);
  assign img_col_clr  = (st == ST_COL_CLR);
  assign img_row_step = (st == ST_ROW_ADV);
  assign img_col_step = (st == ST_COL_ADV);

  assign pix_valid = (st == ST_OUT);
  assign pix_data  = data_q;
  assign pix_row   = row_q;
  assign pix_col   = col_q;
  assign pix_sof   = pix_valid && (row_q == '0) && (col_q == '0);
  assign pix_eof   = pix_valid && last_row && last_col;

  // R4: address pins never overlap
  p_one_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({img_row_clr, img_col_clr, img_row_step, img_col_step}));

  // R7: pointer pins stay quiet during a conversion
  p_quiet_conv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> !(img_row_clr || img_col_clr || img_row_step || img_col_step));

  // R9: a stalled pixel keeps its payload
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=>
      (pix_valid && $stable(pix_data) && $stable(pix_row) && $stable(pix_col)));

  // R2: a row clear only ever follows a start request
  p_clr_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(img_row_clr) |-> $past(frame_start));

  // R11: the end-of-frame handshake leaves the block idle
  p_eof_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && pix_eof) |=>
      (!pix_valid && adc_cs_n && !img_col_clr && !img_col_step && !img_row_step));

endmodule

// File: tb/sim_pix_scan_seq.sv
module sim_pix_scan_seq;

  localparam int COLS  = 5;
  localparam int ROWS  = 4;
  localparam int NPIX  = COLS * ROWS;
  localparam int DW    = 12;
  localparam int HALF  = 2;
  localparam int CNT_W = 4;
  localparam int MINF  = 3000;
  localparam int CW    = $clog2(COLS);
  localparam int RW    = $clog2(ROWS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             frame_start = 1'b0;
  logic [CNT_W-1:0] cfg_pulse_w = '0;
  logic [CNT_W-1:0] cfg_settle = '0;
  logic             img_row_clr, img_col_clr, img_row_step, img_col_step;
  logic             adc_cs_n, adc_sclk;
  logic             adc_miso = 1'b0;
  logic             pix_valid;
  logic             pix_ready = 1'b0;
  logic [DW-1:0]    pix_data;
  logic [RW-1:0]    pix_row;
  logic [CW-1:0]    pix_col;
  logic             pix_sof, pix_eof;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int frames_done = 0;
  int stall_mode  = 0;
  logic [DW-1:0] exp_data [0:255];
  int unsigned seed_v;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pix_scan_seq #(
    .COLS(COLS), .ROWS(ROWS), .DW(DW), .ADC_BITS(16), .ADC_LEAD(2),
    .SCLK_HALF(HALF), .CNT_W(CNT_W), .MIN_FRAME_CYC(MINF)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_pulse_w(cfg_pulse_w), .cfg_settle(cfg_settle),
    .img_row_clr(img_row_clr), .img_col_clr(img_col_clr),
    .img_row_step(img_row_step), .img_col_step(img_col_step),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_miso(adc_miso),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .pix_row(pix_row), .pix_col(pix_col), .pix_sof(pix_sof), .pix_eof(pix_eof)
  );

  function automatic int at_least_one(input int v);
    if (v < 1) return 1;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  // ADC model: word = two zeros, 12-bit sample, two random trailing bits
  initial begin : adc_model
    int k;
    logic [15:0] word;
    logic [DW-1:0] smp;
    k = 0;
    forever begin
      @(negedge adc_cs_n);
      smp  = DW'($urandom);
      word = {2'b00, smp, 2'($urandom)};
      exp_data[k % 256] = smp;
      k++;
      adc_miso = word[15];
      for (int b = 14; b >= 0; b--) begin
        @(negedge adc_sclk);
        adc_miso = word[b];
      end
    end
  end

  // Port monitor and stream consumer
  initial begin : monitor
    logic [3:0] p, prev_p;
    int run [4];
    int cnt_p [4];
    int last_pulse, conv_k, pix_i, sclk_rises, hi_run, settle_n, k;
    bit settling, in_frame, stalled, prev_cs, prev_sclk, rdy;
    logic [DW-1:0] sv_data;
    logic [RW-1:0] sv_row;
    logic [CW-1:0] sv_col;
    prev_p = '0; last_pulse = -1; conv_k = 0; pix_i = 0; sclk_rises = 0;
    hi_run = 0; settle_n = 0; settling = 0; in_frame = 0; stalled = 0;
    prev_cs = 1; prev_sclk = 0; sv_data = '0; sv_row = '0; sv_col = '0;
    for (int i = 0; i < 4; i++) begin run[i] = 0; cnt_p[i] = 0; end
    wait (rst_n);
    forever begin
      @(negedge clk);
      p = {img_col_step, img_row_step, img_col_clr, img_row_clr};
      if ($countones(p) > 1) chk(0, "R4 overlap", $countones(p), 1);
      for (int i = 0; i < 4; i++) begin
        if (p[i]) begin
          run[i]++;
          if (!prev_p[i]) begin
            cnt_p[i]++;
            if (i == 0) in_frame = 1;
            else if (!in_frame) chk(0, "R11 pulse while idle", i, -1);
            if (i == 1)
              chk(last_pulse == (((conv_k % NPIX) / COLS == 0) ? 0 : 2),
                  "R5 col clear predecessor", last_pulse, ((conv_k % NPIX) / COLS == 0) ? 0 : 2);
            last_pulse = i;
          end
        end else if (prev_p[i]) begin
          chk(run[i] == at_least_one(int'(cfg_pulse_w)), "R4 pulse width",
              run[i], at_least_one(int'(cfg_pulse_w)));
          run[i] = 0;
          if (i == 1 || i == 3) begin settling = 1; settle_n = 0; end
        end
      end
      if (settling) begin
        if (adc_cs_n) settle_n++;
        else begin
          chk(settle_n == at_least_one(int'(cfg_settle)), "R6 settle",
              settle_n, at_least_one(int'(cfg_settle)));
          settling = 0;
        end
      end
      // ADC link
      if (!adc_cs_n && prev_cs) begin
        if (!in_frame) chk(0, "R11 conversion while idle", 0, 1);
        chk(last_pulse == ((conv_k % COLS == 0) ? 1 : 3), "R5 step before conversion",
            last_pulse, (conv_k % COLS == 0) ? 1 : 3);
        conv_k++;
        sclk_rises = 0;
      end
      if (!adc_cs_n) begin
        if (p != '0) chk(0, "R7 pin during conversion", int'(p), 0);
        if (adc_sclk && !prev_sclk) sclk_rises++;
      end
      if (adc_cs_n && !prev_cs) chk(sclk_rises == 16, "R7 sclk count", sclk_rises, 16);
      if (adc_cs_n && adc_sclk) chk(0, "R7 sclk idle", 1, 0);
      if (adc_sclk) hi_run++;
      else if (prev_sclk) begin
        chk(hi_run == HALF, "R7 sclk high phase", hi_run, HALF);
        hi_run = 0;
      end
      // stream
      if (pix_valid) begin
        if (!in_frame) chk(0, "R11 valid while idle", 1, 0);
        if (stalled)
          chk(pix_data == sv_data && pix_row == sv_row && pix_col == sv_col,
              "R9 hold under stall", int'(pix_data), int'(sv_data));
        k = pix_i % NPIX;
        chk(pix_data == exp_data[pix_i % 256], "R8 sample", int'(pix_data), int'(exp_data[pix_i % 256]));
        chk(int'(pix_row) == k / COLS, "R10 row", int'(pix_row), k / COLS);
        chk(int'(pix_col) == k % COLS, "R10 col", int'(pix_col), k % COLS);
        chk(pix_sof == (k == 0), "R10 sof", int'(pix_sof), int'(k == 0));
        chk(pix_eof == (k == NPIX - 1), "R10 eof", int'(pix_eof), int'(k == NPIX - 1));
      end else if (stalled) begin
        chk(0, "R9 valid dropped", 0, 1);
      end
      rdy = (stall_mode != 0) ? (($urandom % 4) != 0) : 1'b1;
      pix_ready = rdy;
      stalled = 0;
      if (pix_valid && rdy) begin
        pix_i++;
        if (pix_eof) begin
          chk(cnt_p[0] == 1, "R2 one row clear per frame", cnt_p[0], 1);
          chk(cnt_p[1] == ROWS, "R5 col clears", cnt_p[1], ROWS);
          chk(cnt_p[2] == ROWS - 1, "R5 row steps", cnt_p[2], ROWS - 1);
          chk(cnt_p[3] == ROWS * (COLS - 1), "R5 col steps", cnt_p[3], ROWS * (COLS - 1));
          for (int i = 0; i < 4; i++) cnt_p[i] = 0;
          in_frame = 0;
          frames_done++;
        end
      end else if (pix_valid) begin
        stalled = 1;
        sv_data = pix_data; sv_row = pix_row; sv_col = pix_col;
      end
      prev_p = p; prev_cs = adc_cs_n; prev_sclk = adc_sclk;
    end
  end

  task automatic check_idle_outputs(input string req);
    chk({img_row_clr, img_col_clr, img_row_step, img_col_step} == 4'b0, req,
        int'({img_row_clr, img_col_clr, img_row_step, img_col_step}), 0);
    chk(adc_cs_n == 1'b1, req, int'(adc_cs_n), 1);
    chk(adc_sclk == 1'b0, req, int'(adc_sclk), 0);
    chk(pix_valid == 1'b0, req, int'(pix_valid), 0);
  endtask

  task automatic mid_frame_starts(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (150 + ($urandom % 200)) @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
    end
  endtask

  initial begin : main
    int cx, cx2;
    seed_v = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    check_idle_outputs("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle_outputs("R1 after reset");

    // frame 1: minimum pulse, settle of zero promoted to one, no stalls
    cfg_pulse_w = 4'd1; cfg_settle = 4'd0; stall_mode = 0;
    frame_start = 1'b1; cx = cyc;
    @(negedge clk);
    frame_start = 1'b0;
    chk(img_row_clr == 1'b1, "R2 row clear after start", int'(img_row_clr), 1);
    mid_frame_starts(2);
    wait (frames_done == 1);
    @(negedge clk);
    check_idle_outputs("R11 idle after frame");

    // start right after the frame: still inside the pacing window
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk(img_row_clr == 1'b0, "R3 early start ignored", int'(img_row_clr), 0);
      @(negedge clk);
    end

    // pacing boundary: one edge early is ignored, the boundary edge is accepted
    cfg_pulse_w = 4'd3; cfg_settle = 4'd2; stall_mode = 1;
    while (cyc != cx + MINF - 1) @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    chk(img_row_clr == 1'b0, "R3 start one edge early", int'(img_row_clr), 0);
    cx2 = cyc;
    @(negedge clk);
    frame_start = 1'b0;
    chk(img_row_clr == 1'b1, "R3 start at boundary", int'(img_row_clr), 1);
    mid_frame_starts(3);
    wait (frames_done == 2);

    // frame 3: zero pulse width promoted, long settle, random stalls
    cfg_pulse_w = 4'd0; cfg_settle = 4'd5;
    while (cyc < cx2 + MINF) @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk(img_row_clr == 1'b1, "R2 row clear after start", int'(img_row_clr), 1);
    mid_frame_starts(2);
    wait (frames_done == 3);
    repeat (50) @(negedge clk);
    check_idle_outputs("R11 idle at end");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule